// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block sits behind a byte-level I2C target front end and turns the bytes of a received write into register updates for a four-channel, 16-bit DAC. Each channel has two stages. A staging register holds a value that has been written but not applied yet. An active register drives the analog output code and the channel's power-down state. The front end raises a strobe for the address byte, the control byte, the two data bytes and the end of the transaction. The block answers the address strobe with a combinational acknowledge, in the same cycle.

One control byte sets the whole update. It gives the load mode, the target channel, whether the write carries a code or a power-down request, and two extended address bits that are compared against static pins. In the four load modes a value can be staged without being applied, applied to one channel, applied to one channel while the other three take their staged values, or applied to all channels at once. The last mode is meant for many devices that share one broadcast address, so that they update together.

Top module: `qdac_update_ctrl`

## Requirements
- R1: The block acknowledges a read or write to the 7-bit address {10011, addr_pin[1:0]}. It also acknowledges a write to the broadcast address 1001000, whatever the pins are. Any other address is not acknowledged, and its bytes leave every register unchanged.
- R2: A read to the broadcast address is not acknowledged. A read to the device's own address is acknowledged but changes no register.
- R3: The control byte holds, from bit 7 down to bit 0: extended address [7:6], load mode [5:4], an ignored bit [3], channel select [2:1], power-down flag [0]. In load modes 00, 01 and 10, an update takes effect only if bits [7:6] equal addr_pin[3:2]. In mode 11 this comparison is skipped.
- R4: Load mode 00 writes the selected channel's staging register only. No output changes.
- R5: Load mode 01 writes both the staging register and the active register of the selected channel. The other channels stay as they are.
- R6: Load mode 10 writes both registers of the selected channel. In the same cycle, each of the other three channels copies its staging register into its active register.
- R7: In load mode 11 with select bit [2] = 0, every channel copies its staging register into its active register. Select bit [1] has no effect.
- R8: In load mode 11 with select bit [2] = 1, every channel writes the received value into both its staging and active registers.
- R9: The channel select value is 0 for channel A, 1 for B, 2 for C and 3 for D. Channel n occupies dac_code[16n+15:16n] and pd_state[2n+1:2n].
- R10: A write with the power-down flag = 1 sets the channel's 2-bit power-down mode to data-high bits [7:6] and keeps its code. A write with the flag = 0 loads the code and sets the power-down mode to 00.
- R11: The data word is {high byte, low byte}. It is applied only when the low byte arrives. A transaction that ends before its low byte changes nothing. After a low byte, the next byte of the same transaction is read as a new control byte.
- R12: After reset, every code is 0 and every power-down mode is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_vld | input | 1 | Address byte received (start of transaction) |
| addr7 | input | 7 | Received 7-bit address |
| rd | input | 1 | Read/write bit, 1 = read |
| ctrl_vld | input | 1 | Control byte received |
| ctrl_byte | input | 8 | Control byte |
| hi_vld | input | 1 | High data byte received |
| hi_byte | input | 8 | High data byte |
| lo_vld | input | 1 | Low data byte received |
| lo_byte | input | 8 | Low data byte |
| stop_vld | input | 1 | Transaction ended |
| addr_pin | input | 4 | Static address pins; [1:0] select the bus address, [3:2] are matched against control bits |
| ack | output | 1 | Address acknowledge, valid while start_vld is high |
| dac_code | output | 64 | Active codes of channels D..A, 16 bits each |
| pd_state | output | 8 | Power-down modes of channels D..A, 2 bits each |

## Verification
Directed transactions first use each load mode alone on a known register picture: staged values differ from active ones and from the new value on every channel. This way, a copy from the staging register, a direct write and no change give different outputs. Broadcast-mode writes are sent with wrong extended bits to show that the comparison is skipped. Ordinary writes are sent with wrong bits to show that they are dropped. Writes cut short after the high byte, and two words in one transaction, test when an update is applied. Random transactions with a fixed seed then mix own, broadcast and foreign addresses, reads, pin settings and power-down writes. All four channels are compared after every transaction against a two-stage model in the bench.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef enum logic [1:0] {
      LD_STAGE  = 2'b00,
      LD_SINGLE = 2'b01,
      LD_SYNC   = 2'b10,
      LD_ALL    = 2'b11
   } load_mode_e;

   typedef struct packed {
      logic [1:0]  ext;
      load_mode_e  mode;
      logic        unused;
      logic [1:0]  sel;
      logic        pdn;
   } ctrl_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CTRL,
      PH_HI,
      PH_LO
   } phase_e;

endpackage

// File: rtl/qdac_addr_match.sv
module qdac_addr_match #(
   parameter int         ADDR_W    = 7,
   parameter int         PIN_W     = 2,
   parameter logic [6:0] BCAST_ADR = 7'b1001000,
   parameter logic [4:0] DEV_HI    = 5'b10011
) (
   input  logic              start_vld,
   input  logic [ADDR_W-1:0] addr7,
   input  logic              rd,
   input  logic [PIN_W-1:0]  pin_lo,
   output logic              ack
);

   localparam int HI_W = ADDR_W - PIN_W;

   generate
      if (HI_W != 5) begin : g_bad_w
         $error("qdac_addr_match: address split must leave 5 fixed bits");
      end
   endgenerate

   logic own_hit, bcast_hit;

   always_comb begin
      own_hit   = (addr7 == {DEV_HI, pin_lo});
      bcast_hit = (addr7 == BCAST_ADR) && !rd;
      ack       = start_vld && (own_hit || bcast_hit);
   end

endmodule

// File: rtl/qdac_txn.sv
module qdac_txn
   import qdac_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int BYTE_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_vld,
   input  logic              ack,
   input  logic              rd,
   input  logic              ctrl_vld,
   input  logic [7:0]        ctrl_byte,
   input  logic              hi_vld,
   input  logic [BYTE_W-1:0] hi_byte,
   input  logic              lo_vld,
   input  logic [BYTE_W-1:0] lo_byte,
   input  logic              stop_vld,
   output logic              commit,
   output ctrl_t             ctrl_q,
   output logic [DATA_W-1:0] word
);

   phase_e            ph_q;
   logic [BYTE_W-1:0] hi_q;

   always_comb begin
      commit = lo_vld && (ph_q == PH_LO);
      word   = {hi_q, lo_byte};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         ctrl_q <= '0;
         hi_q   <= '0;
      end else if (start_vld) begin
         ph_q <= (ack && !rd) ? PH_CTRL : PH_IDLE;
      end else if (stop_vld) begin
         ph_q <= PH_IDLE;
      end else begin
         unique case (ph_q)
            PH_CTRL: if (ctrl_vld) begin
               ctrl_q <= ctrl_t'(ctrl_byte);
               ph_q   <= PH_HI;
            end
            PH_HI: if (hi_vld) begin
               hi_q <= hi_byte;
               ph_q <= PH_LO;
            end
            PH_LO: if (lo_vld) ph_q <= PH_CTRL;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
   parameter int DATA_W = 16,
   parameter int PD_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_new_stg,
   input  logic              ld_new_act,
   input  logic              ld_stg2act,
   input  logic              is_pdn,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] code,
   output logic [PD_W-1:0]   pd
);

   logic [DATA_W-1:0] stg_code;
   logic [PD_W-1:0]   stg_pd;
   logic [PD_W-1:0]   pd_req;

   assign pd_req = data[DATA_W-1 -: PD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_code <= '0;
         stg_pd   <= '0;
      end else if (ld_new_stg) begin
         if (is_pdn) begin
            stg_pd <= pd_req;
         end else begin
            stg_code <= data;
            stg_pd   <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         pd   <= '0;
      end else if (ld_new_act) begin
         if (is_pdn) begin
            pd <= pd_req;
         end else begin
            code <= data;
            pd   <= '0;
         end
      end else if (ld_stg2act) begin
         code <= stg_code;
         pd   <= stg_pd;
      end
   end

endmodule

// File: rtl/qdac_update_ctrl.sv
module qdac_update_ctrl
   import qdac_pkg::*;
#(
   parameter int         NUM_CH    = 4,
   parameter int         DATA_W    = 16,
   parameter int         PD_W      = 2,
   parameter logic [6:0] BCAST_ADR = 7'b1001000,
   parameter logic [4:0] DEV_HI    = 5'b10011
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_vld,
   input  logic [6:0]               addr7,
   input  logic                     rd,
   input  logic                     ctrl_vld,
   input  logic [7:0]               ctrl_byte,
   input  logic                     hi_vld,
   input  logic [7:0]               hi_byte,
   input  logic                     lo_vld,
   input  logic [7:0]               lo_byte,
   input  logic                     stop_vld,
   input  logic [3:0]               addr_pin,
   output logic                     ack,
   output logic [NUM_CH*DATA_W-1:0] dac_code,
   output logic [NUM_CH*PD_W-1:0]   pd_state
);

   localparam int SEL_W = $clog2(NUM_CH);

   generate
      if (NUM_CH != 4 || SEL_W != 2) begin : g_bad_ch
         $error("qdac_update_ctrl: control byte addresses exactly four channels");
      end
      if (DATA_W != 16) begin : g_bad_data
         $error("qdac_update_ctrl: data word is two bytes");
      end
      if (PD_W != 2) begin : g_bad_pd
         $error("qdac_update_ctrl: power-down mode is two bits");
      end
   endgenerate

   logic              commit;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] word;
   logic              hit;

   qdac_addr_match #(
      .ADDR_W   (7),
      .PIN_W    (2),
      .BCAST_ADR(BCAST_ADR),
      .DEV_HI   (DEV_HI)
   ) u_match (
      .start_vld(start_vld),
      .addr7    (addr7),
      .rd       (rd),
      .pin_lo   (addr_pin[1:0]),
      .ack      (ack)
   );

   qdac_txn #(
      .DATA_W(DATA_W)
   ) u_txn (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_vld(start_vld),
      .ack      (ack),
      .rd       (rd),
      .ctrl_vld (ctrl_vld),
      .ctrl_byte(ctrl_byte),
      .hi_vld   (hi_vld),
      .hi_byte  (hi_byte),
      .lo_vld   (lo_vld),
      .lo_byte  (lo_byte),
      .stop_vld (stop_vld),
      .commit   (commit),
      .ctrl_q   (ctrl_q),
      .word     (word)
   );

   assign hit = commit && ((ctrl_q.mode == LD_ALL) || (ctrl_q.ext == addr_pin[3:2]));

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic is_sel, new_stg, new_act, stg2act;

      always_comb begin
         is_sel = (ctrl_q.sel == SEL_W'(ch));
         unique case (ctrl_q.mode)
            LD_STAGE: begin
               new_stg = is_sel; new_act = 1'b0; stg2act = 1'b0;
            end
            LD_SINGLE: begin
               new_stg = is_sel; new_act = is_sel; stg2act = 1'b0;
            end
            LD_SYNC: begin
               new_stg = is_sel; new_act = is_sel; stg2act = !is_sel;
            end
            default: begin
               new_stg = ctrl_q.sel[1]; new_act = ctrl_q.sel[1]; stg2act = !ctrl_q.sel[1];
            end
         endcase
      end

      qdac_chan #(
         .DATA_W(DATA_W),
         .PD_W  (PD_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld_new_stg(hit && new_stg),
         .ld_new_act(hit && new_act),
         .ld_stg2act(hit && stg2act),
         .is_pdn    (ctrl_q.pdn),
         .data      (word),
         .code      (dac_code[ch*DATA_W +: DATA_W]),
         .pd        (pd_state[ch*PD_W +: PD_W])
      );
   end

endmodule

// File: rtl/qdac_update_chk.sv
module qdac_update_chk #(
   parameter int         NUM_CH    = 4,
   parameter int         DATA_W    = 16,
   parameter int         PD_W      = 2,
   parameter logic [6:0] BCAST_ADR = 7'b1001000,
   parameter logic [4:0] DEV_HI    = 5'b10011
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start_vld,
   input logic [6:0]               addr7,
   input logic                     rd,
   input logic                     ack,
   input logic                     commit,
   input logic [7:0]               ctrl_q,
   input logic [DATA_W-1:0]        word,
   input logic [3:0]               addr_pin,
   input logic [NUM_CH*DATA_W-1:0] dac_code,
   input logic [NUM_CH*PD_W-1:0]   pd_state
);

   logic [1:0]        last_sel;
   logic [DATA_W-1:0] last_word;
   logic              ext_ok;
   logic [1:0]        mode;

   assign ext_ok = (ctrl_q[7:6] == addr_pin[3:2]);
   assign mode   = ctrl_q[5:4];

   always_ff @(posedge clk) begin
      last_sel  <= ctrl_q[2:1];
      last_word <= word;
   end

   function automatic logic [DATA_W-1:0] code_of(input logic [NUM_CH*DATA_W-1:0] v,
                                                 input logic [1:0] s);
      return v[s*DATA_W +: DATA_W];
   endfunction

   function automatic logic [PD_W-1:0] pd_of(input logic [NUM_CH*PD_W-1:0] v,
                                             input logic [1:0] s);
      return v[s*PD_W +: PD_W];
   endfunction

   assert_own_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_vld && (addr7 == {DEV_HI, addr_pin[1:0]}) |-> ack);

   assert_bcast_rd_nak_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_vld && (addr7 == BCAST_ADR) && rd |-> !ack);

   assert_ext_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit && (mode != 2'b11) && !ext_ok |=> $stable(dac_code) && $stable(pd_state));

   assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      commit && (mode == 2'b00) |=> $stable(dac_code) && $stable(pd_state));

   assert_single_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit && (mode == 2'b01) && ext_ok && !ctrl_q[0]
      |=> (code_of(dac_code, last_sel) == last_word) && (pd_of(pd_state, last_sel) == '0));

   assert_pdn_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit && (mode == 2'b01) && ext_ok && ctrl_q[0]
      |=> pd_of(pd_state, last_sel) == last_word[DATA_W-1 -: PD_W]);

   assert_no_commit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(dac_code) && $stable(pd_state));

endmodule

bind qdac_update_ctrl qdac_update_chk #(
   .NUM_CH   (NUM_CH),
   .DATA_W   (DATA_W),
   .PD_W     (PD_W),
   .BCAST_ADR(BCAST_ADR),
   .DEV_HI   (DEV_HI)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_vld(start_vld),
   .addr7    (addr7),
   .rd       (rd),
   .ack      (ack),
   .commit   (commit),
   .ctrl_q   (ctrl_q),
   .word     (word),
   .addr_pin (addr_pin),
   .dac_code (dac_code),
   .pd_state (pd_state)
);

// File: tb/tb_qdac_update_ctrl.sv
`timescale 1ns/1ps
module tb_qdac_update_ctrl;

   localparam logic [6:0] BCAST = 7'b1001000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_vld = 1'b0, rd = 1'b0;
   logic [6:0]  addr7 = '0;
   logic        ctrl_vld = 1'b0, hi_vld = 1'b0, lo_vld = 1'b0, stop_vld = 1'b0;
   logic [7:0]  ctrl_byte = '0, hi_byte = '0, lo_byte = '0;
   logic [3:0]  addr_pin = '0;
   logic        ack;
   logic [63:0] dac_code;
   logic [7:0]  pd_state;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] m_sc[4], m_ac[4];
   logic [1:0]  m_sp[4], m_ap[4];
   logic        m_open;

   always #2.5 clk = ~clk;

   qdac_update_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .addr7(addr7), .rd(rd),
      .ctrl_vld(ctrl_vld), .ctrl_byte(ctrl_byte), .hi_vld(hi_vld), .hi_byte(hi_byte),
      .lo_vld(lo_vld), .lo_byte(lo_byte), .stop_vld(stop_vld), .addr_pin(addr_pin),
      .ack(ack), .dac_code(dac_code), .pd_state(pd_state)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_code();
      return {m_ac[3], m_ac[2], m_ac[1], m_ac[0]};
   endfunction

   function automatic logic [7:0] exp_pd();
      return {m_ap[3], m_ap[2], m_ap[1], m_ap[0]};
   endfunction

   function automatic logic exp_ack(input logic [6:0] a, input logic r, input logic [3:0] p);
      return (a == {5'b10011, p[1:0]}) || (a == BCAST && !r);
   endfunction

   task automatic m_apply(input logic [7:0] c, input logic [15:0] w);
      logic [1:0] mode = c[5:4];
      logic       go = (mode == 2'b11) || (c[7:6] == addr_pin[3:2]);
      for (int i = 0; i < 4; i++) begin
         logic sel = (c[2:1] == 2'(i));
         logic ns, na, cp;
         case (mode)
            2'b00:   begin ns = sel;  na = 1'b0; cp = 1'b0;  end
            2'b01:   begin ns = sel;  na = sel;  cp = 1'b0;  end
            2'b10:   begin ns = sel;  na = sel;  cp = !sel;  end
            default: begin ns = c[2]; na = c[2]; cp = !c[2]; end
         endcase
         if (go) begin
            if (na) begin
               if (c[0]) m_ap[i] = w[15:14];
               else begin m_ac[i] = w; m_ap[i] = 2'b00; end
            end else if (cp) begin
               m_ac[i] = m_sc[i]; m_ap[i] = m_sp[i];
            end
            if (ns) begin
               if (c[0]) m_sp[i] = w[15:14];
               else begin m_sc[i] = w; m_sp[i] = 2'b00; end
            end
         end
      end
   endtask

   task automatic t_start(input logic [6:0] a, input logic r, input string tag);
      addr7 = a; rd = r; start_vld = 1'b1;
      #1;
      chk(tag, {63'd0, ack}, {63'd0, exp_ack(a, r, addr_pin)});
      m_open = exp_ack(a, r, addr_pin) && !r;
      @(negedge clk) start_vld = 1'b0;
   endtask

   task automatic t_word(input logic [7:0] c, input logic [15:0] w, input logic full);
      ctrl_byte = c; ctrl_vld = 1'b1;
      @(negedge clk) ctrl_vld = 1'b0; hi_byte = w[15:8]; hi_vld = 1'b1;
      @(negedge clk) hi_vld = 1'b0;
      if (full) begin
         lo_byte = w[7:0]; lo_vld = 1'b1;
         @(negedge clk) lo_vld = 1'b0;
         if (m_open) m_apply(c, w);
      end
   endtask

   task automatic t_stop();
      stop_vld = 1'b1;
      @(negedge clk) stop_vld = 1'b0;
      m_open = 1'b0;
   endtask

   task automatic check_out(input string tag);
      chk({tag, " code"}, dac_code, exp_code());
      chk({tag, " pd"}, {56'd0, pd_state}, {56'd0, exp_pd()});
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] c, input logic [15:0] w,
                     input string tag);
      t_start(a, 1'b0, tag);
      t_word(c, w, 1'b1);
      t_stop();
      check_out(tag);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [6:0] own;
      for (int i = 0; i < 4; i++) begin
         m_sc[i] = '0; m_ac[i] = '0; m_sp[i] = '0; m_ap[i] = '0;
      end
      m_open = 1'b0;
      addr_pin = 4'b1001;
      own = {5'b10011, addr_pin[1:0]};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R12 reset");

      // R9/R4: stage distinct values in every channel, outputs stay 0
      for (int i = 0; i < 4; i++)
         wr(own, {2'b10, 2'b00, 1'b0, 2'(i), 1'b0}, 16'h1110 * 16'(i + 1), "R4 R9 stage");
      // R5: direct write to channel C only
      wr(own, {2'b10, 2'b01, 1'b0, 2'd2, 1'b0}, 16'hC0DE, "R5 single");
      // R3: ext mismatch dropped
      wr(own, {2'b01, 2'b01, 1'b0, 2'd0, 1'b0}, 16'hDEAD, "R3 ext mismatch");
      // R6: sync on B, others copy staged
      wr(own, {2'b10, 2'b10, 1'b0, 2'd1, 1'b0}, 16'hBEEF, "R6 sync");
      // R10: power-down on D, then data write clears it
      wr(own, {2'b10, 2'b01, 1'b0, 2'd3, 1'b1}, 16'h8000, "R10 pdn set");
      wr(own, {2'b10, 2'b01, 1'b0, 2'd3, 1'b0}, 16'h0042, "R10 pdn clear");
      // stage new values, then R7 copy-all via broadcast with wrong ext bits
      for (int i = 0; i < 4; i++)
         wr(own, {2'b10, 2'b00, 1'b0, 2'(i), 1'b0}, 16'h5A00 + 16'(i), "R4 restage");
      wr(BCAST, {2'b00, 2'b11, 1'b0, 2'b01, 1'b0}, 16'hFFFF, "R7 bcast copy");
      // R8: broadcast new data into all
      wr(BCAST, {2'b01, 2'b11, 1'b0, 2'b10, 1'b0}, 16'h1234, "R8 bcast data");
      wr(BCAST, {2'b01, 2'b11, 1'b0, 2'b10, 1'b1}, 16'h4000, "R8 R10 bcast pdn");
      // R2: broadcast read not acked; own read acked, no change
      t_start(BCAST, 1'b1, "R2 bcast read");
      t_stop();
      t_start(own, 1'b1, "R2 own read");
      t_word({2'b10, 2'b01, 1'b0, 2'd0, 1'b0}, 16'h7777, 1'b1);
      t_stop();
      check_out("R2 read no write");
      // R1: foreign address ignored
      t_start(7'b1001111 ^ 7'b0000011 ^ {5'd0, addr_pin[1:0]} ^ 7'b0000100, 1'b0, "R1 foreign");
      t_word({2'b10, 2'b01, 1'b0, 2'd0, 1'b0}, 16'h6666, 1'b1);
      t_stop();
      check_out("R1 foreign no write");
      // R11: aborted word, then two words in one transaction
      t_start(own, 1'b0, "R11 abort start");
      t_word({2'b10, 2'b01, 1'b0, 2'd1, 1'b0}, 16'h9999, 1'b0);
      t_stop();
      check_out("R11 abort");
      t_start(own, 1'b0, "R11 multi start");
      t_word({2'b10, 2'b01, 1'b0, 2'd0, 1'b0}, 16'hA5A5, 1'b1);
      t_word({2'b10, 2'b01, 1'b0, 2'd1, 1'b0}, 16'h5A5A, 1'b1);
      t_stop();
      check_out("R11 multi word");

      // random mix
      void'($urandom(32'd2024));
      for (int n = 0; n < 400; n++) begin
         logic [6:0] a;
         logic [7:0] c;
         int         pick = $urandom_range(0, 9);
         addr_pin = 4'($urandom);
         own = {5'b10011, addr_pin[1:0]};
         a = (pick < 6) ? own : (pick < 8) ? BCAST : 7'($urandom);
         c = 8'($urandom);
         if ($urandom_range(0, 3) != 0) c[7:6] = addr_pin[3:2];
         t_start(a, ($urandom_range(0, 7) == 0), "R1 R2 random ack");
         t_word(c, 16'($urandom), ($urandom_range(0, 9) != 0));
         t_stop();
         check_out($sformatf("R%0d random mode", (c[5:4] == 2'b00) ? 4 :
                                                  (c[5:4] == 2'b01) ? 5 :
                                                  (c[5:4] == 2'b10) ? 6 : 8));
      end
      summary();
   end

endmodule